// File: doc/BRIEF.md
# Register-Write Command Queue Engine

This engine runs a list of 64-bit instructions held in a local command memory. Each instruction takes two consecutive 32-bit words: a data word followed by a control word. Software sets a head word address and then writes a tail word address while the enable input is high. The engine then fetches and executes instructions from the head onward. It stops once its fetch pointer reaches or passes the tail.

Only writes leave the engine. Register writes go out on a write-only register bus that carries per-byte enables. The engine also handles no-ops, waits paced by a one-microsecond tick, waits for a number of vblank pulses, and a sticky completion interrupt. Scanline-window waits go to an external window-wait unit through a start/done handshake. Indexed bursts go to an external burst expander the same way. A halt input aborts a running program. Sticky flags report an unknown opcode and a refused start.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, busy, prog_irq, err_op and err_align are 0, and none of rb_wr, win_start, burst_start or mem_rd is asserted.
- R2: A start is a tail_wr pulse with enable high while the engine is idle. If the tail is 16-word aligned (tail[3:0]==0), the start is accepted: busy rises and execution begins at head. busy falls once the next instruction address is at or beyond the tail. A start with head equal to tail runs nothing. A tail_wr with enable low, or one that arrives while busy, is ignored.
- R3: A start with a tail that is not 16-word aligned is refused. busy stays 0 and err_align is set. Both error flags are cleared by the next accepted start.
- R4: Opcode 0x01 (control word bits 31:24) is a register write. It produces exactly one rb_wr pulse. rb_be comes from control bits 23:20, rb_addr from control bits 19:0, and rb_data from the data word. Bit i of rb_be enables byte i.
- R5: Opcode 0x00 is a no-op. It causes no bus activity, and execution continues with the next instruction.
- R6: Opcode 0x02 holds off the next instruction until as many tick_us pulses as the data word gives have been counted. A count of 0 does not wait.
- R7: Opcode 0x04 holds off the next instruction until as many vblank pulses as the data word gives have been counted.
- R8: Opcode 0x07 sets the sticky prog_irq output. An irq_clr pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: Opcodes 0x05 (wait inside window, win_out_mode=0) and 0x06 (wait outside window, win_out_mode=1) issue a one-cycle win_start pulse. win_lo is data bits 19:0. win_hi is {control bits 7:0, data bits 31:20}. Execution resumes only after win_done.
- R10: Opcode 0x09 issues a one-cycle burst_start pulse. burst_reg is control bits 19:0, burst_len is the data word, and burst_addr is the instruction address plus 2. After burst_done, execution resumes at that address plus burst_len rounded up to an even count.
- R11: Any other opcode, including 0x03, 0x0A and 0x0C, sets the sticky err_op flag. The engine stops with busy cleared and no bus write.
- R12: A halt pulse while busy clears busy on the next cycle. Nothing further is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Engine enable; qualifies a start |
| head | input | AW | Start word address |
| tail_wr | input | 1 | Tail write strobe (start request) |
| tail | input | AW | End word address |
| halt | input | 1 | Abort a running program |
| irq_clr | input | 1 | Write-one clear of prog_irq |
| tick_us | input | 1 | One-microsecond tick |
| vblank | input | 1 | Vblank pulse |
| mem_rd | output | 1 | Command memory read strobe |
| mem_addr | output | AW | Command memory word address |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| rb_wr | output | 1 | Register bus write strobe |
| rb_addr | output | 20 | Register offset |
| rb_data | output | 32 | Write value |
| rb_be | output | 4 | Byte enables |
| win_start | output | 1 | Window wait request pulse |
| win_out_mode | output | 1 | 0 wait inside, 1 wait outside |
| win_lo | output | 20 | Window lower scanline |
| win_hi | output | 20 | Window upper scanline |
| win_done | input | 1 | Window wait finished |
| burst_start | output | 1 | Indexed burst request pulse |
| burst_reg | output | 20 | Burst register offset |
| burst_len | output | 32 | Number of burst data words |
| burst_addr | output | AW | Word address of first burst data word |
| burst_done | input | 1 | Burst finished |
| busy | output | 1 | Program running |
| prog_irq | output | 1 | Sticky program interrupt |
| err_op | output | 1 | Sticky unknown opcode flag |
| err_align | output | 1 | Sticky refused-start flag |

## Verification
If the fetch pointer goes wrong, for example after a burst skip that does not round to an even count, a data or pad word is decoded as a control word. Within a few cycles this shows up as a spurious err_op or as a missing or extra rb_wr. A wait counter that loads or decrements wrongly moves the following register write by whole tick or vblank periods, so the bench counts pulses before it expects that write. A wrong busy/stop condition shows as busy that never falls, which the bench sees as a timeout, or as a busy that falls before the last write.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int REG_W  = 20;
    localparam int WORD_W = 32;

    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_WR   = 8'h01;
    localparam logic [7:0] OPC_WUS  = 8'h02;
    localparam logic [7:0] OPC_WVB  = 8'h04;
    localparam logic [7:0] OPC_WIN  = 8'h05;
    localparam logic [7:0] OPC_WOUT = 8'h06;
    localparam logic [7:0] OPC_IRQ  = 8'h07;
    localparam logic [7:0] OPC_IDX  = 8'h09;

    typedef enum logic [3:0] {
        K_NOP, K_WR, K_WUS, K_WVB, K_WIN, K_WOUT, K_IRQ, K_IDX, K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_EXEC, S_WUS, S_WVB, S_WWIN, S_WBUR
    } state_e;

    typedef struct packed {
        kind_e              kind;
        logic [3:0]         be;
        logic [REG_W-1:0]   reg_off;
        logic [WORD_W-1:0]  data;
        logic [REG_W-1:0]   w_lo;
        logic [REG_W-1:0]   w_hi;
    } instr_t;

    // words consumed by an indexed burst: header pair plus data padded to even
    function automatic logic [WORD_W-1:0] burst_span(input logic [WORD_W-1:0] n);
        return 32'd2 + n + {31'd0, n[0]};
    endfunction

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output instr_t            ins
);
    always_comb begin
        ins.be      = hi_word[23:20];
        ins.reg_off = hi_word[19:0];
        ins.data    = lo_word;
        ins.w_lo    = lo_word[19:0];
        ins.w_hi    = {hi_word[7:0], lo_word[31:20]};
        case (hi_word[31:24])
            OPC_NOP:  ins.kind = K_NOP;
            OPC_WR:   ins.kind = K_WR;
            OPC_WUS:  ins.kind = K_WUS;
            OPC_WVB:  ins.kind = K_WVB;
            OPC_WIN:  ins.kind = K_WIN;
            OPC_WOUT: ins.kind = K_WOUT;
            OPC_IRQ:  ins.kind = K_IRQ;
            OPC_IDX:  ins.kind = K_IDX;
            default:  ins.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/cmdq_wait_ctr.sv
module cmdq_wait_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R6 / R7: an idle counter never grows on its own
    p_count_descends_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear) |=> (cnt <= $past(cnt)));

    // R6: a tick on a nonzero count always consumes one unit
    p_tick_consumes_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear && tick && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int AW         = 10,
    parameter int LINE_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [AW-1:0]     head,
    input  logic              tail_wr,
    input  logic [AW-1:0]     tail,
    input  logic              halt,
    input  logic              irq_clr,
    input  logic              tick_us,
    input  logic              vblank,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              rb_wr,
    output logic [19:0]       rb_addr,
    output logic [31:0]       rb_data,
    output logic [3:0]        rb_be,
    output logic              win_start,
    output logic              win_out_mode,
    output logic [19:0]       win_lo,
    output logic [19:0]       win_hi,
    input  logic              win_done,
    output logic              burst_start,
    output logic [19:0]       burst_reg,
    output logic [31:0]       burst_len,
    output logic [AW-1:0]     burst_addr,
    input  logic              burst_done,
    output logic              busy,
    output logic              prog_irq,
    output logic              err_op,
    output logic              err_align
);
    localparam int ALIGN_BITS = $clog2(LINE_WORDS);

    state_e              st;
    logic [AW-1:0]       ptr;
    logic [AW-1:0]       tail_q;
    logic [WORD_W-1:0]   lo_q;
    logic [AW-1:0]       span_q;
    instr_t              ins;

    logic                us_zero, vb_zero;
    logic                us_load, vb_load;
    logic                abort;
    logic [AW-1:0]       step;
    logic [AW-1:0]       nxt_ptr;
    logic                nxt_end;
    logic                misaligned;

    cmdq_decode u_dec (
        .lo_word (lo_q),
        .hi_word (mem_rdata),
        .ins     (ins)
    );

    assign abort   = halt && (st != S_IDLE);
    assign us_load = (st == S_EXEC) && (ins.kind == K_WUS) && !abort;
    assign vb_load = (st == S_EXEC) && (ins.kind == K_WVB) && !abort;

    cmdq_wait_ctr #(.W(WORD_W)) u_us (
        .clk (clk), .rst (rst), .load (us_load), .load_val (ins.data),
        .clear (abort), .tick (tick_us), .zero (us_zero)
    );

    cmdq_wait_ctr #(.W(WORD_W)) u_vb (
        .clk (clk), .rst (rst), .load (vb_load), .load_val (ins.data),
        .clear (abort), .tick (vblank), .zero (vb_zero)
    );

    assign busy       = (st != S_IDLE);
    assign mem_rd     = (st == S_RD0) || (st == S_RD1);
    assign mem_addr   = (st == S_RD1) ? ptr + AW'(1) : ptr;
    assign misaligned = (tail[ALIGN_BITS-1:0] != '0);

    assign step    = (st == S_WBUR) ? span_q : AW'(2);
    assign nxt_ptr = ptr + step;
    assign nxt_end = (nxt_ptr >= tail_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            ptr          <= '0;
            tail_q       <= '0;
            lo_q         <= '0;
            span_q       <= '0;
            rb_wr        <= 1'b0;
            rb_addr      <= '0;
            rb_data      <= '0;
            rb_be        <= '0;
            win_start    <= 1'b0;
            win_out_mode <= 1'b0;
            win_lo       <= '0;
            win_hi       <= '0;
            burst_start  <= 1'b0;
            burst_reg    <= '0;
            burst_len    <= '0;
            burst_addr   <= '0;
            prog_irq     <= 1'b0;
            err_op       <= 1'b0;
            err_align    <= 1'b0;
        end else begin
            rb_wr       <= 1'b0;
            win_start   <= 1'b0;
            burst_start <= 1'b0;
            if (irq_clr) prog_irq <= 1'b0;

            if (abort) begin
                st <= S_IDLE;
            end else begin
                case (st)
                    S_IDLE: begin
                        if (tail_wr && enable) begin
                            if (misaligned) begin
                                err_align <= 1'b1;
                            end else begin
                                err_align <= 1'b0;
                                err_op    <= 1'b0;
                                tail_q    <= tail;
                                ptr       <= head;
                                if (head != tail) st <= S_RD0;
                            end
                        end
                    end
                    S_RD0: st <= S_RD1;
                    S_RD1: begin
                        lo_q <= mem_rdata;
                        st   <= S_EXEC;
                    end
                    S_EXEC: begin
                        case (ins.kind)
                            K_NOP, K_WR, K_IRQ: begin
                                if (ins.kind == K_WR) begin
                                    rb_wr   <= 1'b1;
                                    rb_addr <= ins.reg_off;
                                    rb_data <= ins.data;
                                    rb_be   <= ins.be;
                                end
                                if (ins.kind == K_IRQ) prog_irq <= 1'b1;
                                ptr <= nxt_ptr;
                                st  <= nxt_end ? S_IDLE : S_RD0;
                            end
                            K_WUS: st <= S_WUS;
                            K_WVB: st <= S_WVB;
                            K_WIN, K_WOUT: begin
                                win_start    <= 1'b1;
                                win_out_mode <= (ins.kind == K_WOUT);
                                win_lo       <= ins.w_lo;
                                win_hi       <= ins.w_hi;
                                st           <= S_WWIN;
                            end
                            K_IDX: begin
                                burst_start <= 1'b1;
                                burst_reg   <= ins.reg_off;
                                burst_len   <= ins.data;
                                burst_addr  <= ptr + AW'(2);
                                span_q      <= AW'(burst_span(ins.data));
                                st          <= S_WBUR;
                            end
                            default: begin
                                err_op <= 1'b1;
                                st     <= S_IDLE;
                            end
                        endcase
                    end
                    S_WUS, S_WVB, S_WWIN, S_WBUR: begin
                        if ((st == S_WUS  && us_zero)  ||
                            (st == S_WVB  && vb_zero)  ||
                            (st == S_WWIN && win_done) ||
                            (st == S_WBUR && burst_done)) begin
                            ptr <= nxt_ptr;
                            st  <= nxt_end ? S_IDLE : S_RD0;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R12: halt while running empties the engine without a write
    p_halt_stops_r12: assert property (@(posedge clk) disable iff (rst)
        (halt && busy) |=> (!busy && !rb_wr));

    // R8: the program interrupt persists until cleared
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (prog_irq && !irq_clr) |=> prog_irq);

    // R11: a decode error leaves the engine idle
    p_bad_opcode_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(err_op) |-> !busy);

    // R3: a misaligned tail never starts a run
    p_misaligned_refused_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && tail_wr && enable && misaligned) |=> (!busy && err_align));

    // R9: window request is a single-cycle pulse
    p_win_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        win_start |=> !win_start);

    // R10: burst request is a single-cycle pulse
    p_burst_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !burst_start);

    // R4: bus writes only follow a running engine
    p_write_while_running_r4: assert property (@(posedge clk) disable iff (rst)
        rb_wr |-> $past(busy));
endmodule

// File: tb/cmdq_engine_tb_top.sv
module cmdq_engine_tb_top;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          enable = 1'b0, tail_wr = 1'b0, halt = 1'b0, irq_clr = 1'b0;
    logic          tick_us = 1'b0, vblank = 1'b0;
    logic [AW-1:0] head = '0, tail = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          rb_wr;
    logic [19:0]   rb_addr;
    logic [31:0]   rb_data;
    logic [3:0]    rb_be;
    logic          win_start, win_out_mode, win_done;
    logic [19:0]   win_lo, win_hi;
    logic          burst_start, burst_done;
    logic [19:0]   burst_reg;
    logic [31:0]   burst_len;
    logic [AW-1:0] burst_addr;
    logic          busy, prog_irq, err_op, err_align;

    cmdq_engine #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .head(head), .tail_wr(tail_wr),
        .tail(tail), .halt(halt), .irq_clr(irq_clr), .tick_us(tick_us),
        .vblank(vblank), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .rb_wr(rb_wr), .rb_addr(rb_addr),
        .rb_data(rb_data), .rb_be(rb_be), .win_start(win_start),
        .win_out_mode(win_out_mode), .win_lo(win_lo), .win_hi(win_hi),
        .win_done(win_done), .burst_start(burst_start), .burst_reg(burst_reg),
        .burst_len(burst_len), .burst_addr(burst_addr), .burst_done(burst_done),
        .busy(busy), .prog_irq(prog_irq), .err_op(err_op), .err_align(err_align)
    );

    // command memory model, one-cycle read latency
    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    // register bus log
    int          nwr = 0;
    logic [19:0] wr_addr [0:63];
    logic [31:0] wr_data [0:63];
    logic [3:0]  wr_be   [0:63];
    always @(posedge clk) if (rb_wr) begin
        wr_addr[nwr[5:0]] <= rb_addr;
        wr_data[nwr[5:0]] <= rb_data;
        wr_be[nwr[5:0]]   <= rb_be;
        nwr <= nwr + 1;
    end

    // window-wait and burst responders
    int          nwin = 0, win_cnt = 0, bur_cnt = 0, nbur = 0;
    logic        cap_mode;
    logic [19:0] cap_lo, cap_hi, cap_breg;
    logic [31:0] cap_blen;
    logic [AW-1:0] cap_baddr;
    initial begin win_done = 1'b0; burst_done = 1'b0; end
    always @(posedge clk) begin
        win_done   <= (win_cnt == 1);
        burst_done <= (bur_cnt == 1);
        if (win_cnt > 0) win_cnt <= win_cnt - 1;
        if (bur_cnt > 0) bur_cnt <= bur_cnt - 1;
        if (win_start) begin
            cap_mode <= win_out_mode; cap_lo <= win_lo; cap_hi <= win_hi;
            nwin <= nwin + 1; win_cnt <= 8;
        end
        if (burst_start) begin
            cap_breg <= burst_reg; cap_blen <= burst_len; cap_baddr <= burst_addr;
            nbur <= nbur + 1; bur_cnt <= 4;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hi_of(input logic [7:0] op, input logic [3:0] be,
                                          input logic [19:0] r);
        return {op, be, r};
    endfunction

    task automatic put(input int a, input logic [31:0] lo, input logic [31:0] hi);
        mem[a] = lo; mem[a+1] = hi;
    endtask

    task automatic start(input int h, input int t, input logic en);
        @(negedge clk);
        head = AW'(h); tail = AW'(t); enable = en; tail_wr = 1'b1;
        @(negedge clk);
        tail_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n, input logic vb);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); if (vb) vblank = 1'b1; else tick_us = 1'b1;
            @(negedge clk); vblank = 1'b0; tick_us = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 flags", {prog_irq, err_op, err_align}, 0);
        chk("R1 strobes", {rb_wr, win_start, burst_start, mem_rd}, 0);
    endtask

    task automatic t_write();
        int n0 = nwr;
        put(0, 32'hDEAD_BEEF, hi_of(8'h01, 4'hF, 20'h00123));
        put(2, 32'h1234_5678, hi_of(8'h01, 4'h5, 20'h00456));
        put(4, 32'hFFFF_FFFF, hi_of(8'h00, 4'hF, 20'h00789));
        start(0, 16, 1'b1);
        chk("R2 busy after start", busy, 1);
        wait_idle();
        chk("R2 idle at tail", busy, 0);
        chk("R4 R5 write count", nwr - n0, 2);
        chk("R4 addr0", wr_addr[n0], 20'h00123);
        chk("R4 data0", wr_data[n0], 32'hDEAD_BEEF);
        chk("R4 be0", wr_be[n0], 4'hF);
        chk("R4 addr1", wr_addr[n0+1], 20'h00456);
        chk("R4 be1", wr_be[n0+1], 4'h5);
        // enable low: ignored
        start(0, 16, 1'b0);
        chk("R2 enable low ignored", busy, 0);
        // head equals tail: nothing runs
        start(0, 0, 1'b1);
        repeat (4) @(negedge clk);
        chk("R2 empty program", {28'd0, busy} + (nwr - n0), 2);
    endtask

    task automatic t_align();
        start(0, 20, 1'b1);
        chk("R3 refused busy", busy, 0);
        chk("R3 err_align", err_align, 1);
        start(0, 16, 1'b1);
        wait_idle();
        chk("R3 cleared on start", err_align, 0);
    endtask

    task automatic t_wait_us();
        int n0;
        put(16, 32'd3, hi_of(8'h02, 4'h0, 20'h0));
        put(18, 32'hAAAA_0001, hi_of(8'h01, 4'hF, 20'h00011));
        n0 = nwr;
        start(16, 32, 1'b1);
        repeat (6) @(negedge clk);
        pulse_tick(2, 1'b0);
        repeat (6) @(negedge clk);
        chk("R6 held after 2 ticks", nwr - n0, 0);
        chk("R6 busy while waiting", busy, 1);
        pulse_tick(1, 1'b0);
        wait_idle();
        chk("R6 write after 3rd tick", nwr - n0, 1);
        // zero count
        put(32, 32'd0, hi_of(8'h02, 4'h0, 20'h0));
        put(34, 32'hAAAA_0002, hi_of(8'h01, 4'hF, 20'h00022));
        n0 = nwr;
        start(32, 48, 1'b1);
        wait_idle();
        chk("R6 zero count no wait", nwr - n0, 1);
    endtask

    task automatic t_vblank();
        int n0;
        put(144, 32'd2, hi_of(8'h04, 4'h0, 20'h0));
        put(146, 32'hBBBB_0001, hi_of(8'h01, 4'hF, 20'h00033));
        n0 = nwr;
        start(144, 160, 1'b1);
        repeat (6) @(negedge clk);
        pulse_tick(1, 1'b1);
        pulse_tick(3, 1'b0);
        repeat (6) @(negedge clk);
        chk("R7 held after 1 vblank", nwr - n0, 0);
        pulse_tick(1, 1'b1);
        wait_idle();
        chk("R7 write after 2nd vblank", nwr - n0, 1);
    endtask

    task automatic t_irq();
        put(160, 32'h0, hi_of(8'h07, 4'h0, 20'h0));
        start(160, 176, 1'b1);
        wait_idle();
        chk("R8 irq set", prog_irq, 1);
        repeat (3) @(negedge clk);
        chk("R8 irq sticky", prog_irq, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R8 irq cleared", prog_irq, 0);
    endtask

    task automatic t_window();
        int n0, w0;
        put(112, 32'h5670_0123, hi_of(8'h05, 4'h0, 20'h00004));
        put(114, 32'hCCCC_0001, hi_of(8'h01, 4'hF, 20'h00044));
        put(116, 32'h0010_0002, hi_of(8'h06, 4'h0, 20'h00000));
        n0 = nwr; w0 = nwin;
        start(112, 128, 1'b1);
        for (int i = 0; i < 50 && nwin == w0; i++) @(negedge clk);
        chk("R9 in-window mode", cap_mode, 0);
        chk("R9 lower scanline", cap_lo, 20'h00123);
        chk("R9 upper scanline", cap_hi, 20'h04567);
        chk("R9 waits for done", nwr - n0, 0);
        wait_idle();
        chk("R9 write after done", nwr - n0, 1);
        chk("R9 out-window mode", cap_mode, 1);
        chk("R9 second upper", cap_hi, 20'h00001);
        chk("R9 two requests", nwin - w0, 2);
    endtask

    task automatic t_burst();
        int n0;
        put(128, 32'd3, hi_of(8'h09, 4'h0, 20'h00ABC));
        mem[130] = 32'h1; mem[131] = 32'h2; mem[132] = 32'h3; mem[133] = 32'h0;
        put(134, 32'hEE00_0001, hi_of(8'h01, 4'hF, 20'h00055));
        n0 = nwr;
        start(128, 144, 1'b1);
        wait_idle();
        chk("R10 burst reg", cap_breg, 20'h00ABC);
        chk("R10 burst len", cap_blen, 3);
        chk("R10 burst addr", 32'(cap_baddr), 130);
        chk("R10 resumed after pad", nwr - n0, 1);
        chk("R10 no decode error", err_op, 0);
        chk("R10 write data", wr_data[n0], 32'hEE00_0001);
    endtask

    task automatic t_bad();
        int n0;
        put(96, 32'h0, hi_of(8'h0C, 4'h0, 20'h0));
        put(98, 32'hDDDD_0001, hi_of(8'h01, 4'hF, 20'h00066));
        n0 = nwr;
        start(96, 112, 1'b1);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R11 err_op set", err_op, 1);
        chk("R11 busy cleared", busy, 0);
        chk("R11 no write", nwr - n0, 0);
        start(0, 16, 1'b1);
        wait_idle();
        chk("R11 cleared by start", err_op, 0);
    endtask

    task automatic t_halt();
        int n0;
        put(64, 32'd5, hi_of(8'h02, 4'h0, 20'h0));
        put(66, 32'hFFFF_0001, hi_of(8'h01, 4'hF, 20'h00077));
        n0 = nwr;
        start(64, 80, 1'b1);
        repeat (6) @(negedge clk);
        chk("R12 running before halt", busy, 1);
        halt = 1'b1; @(negedge clk); halt = 1'b0;
        chk("R12 busy dropped", busy, 0);
        pulse_tick(7, 1'b0);
        repeat (6) @(negedge clk);
        chk("R12 nothing executed", nwr - n0, 0);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_align();
        t_wait_us();
        t_vblank();
        t_irq();
        t_window();
        t_burst();
        t_bad();
        t_halt();
        summary();
        $finish;
    end
endmodule